// File: doc/BRIEF.md
# Word-Stuffed Link Framer

The block frames traffic for one full-duplex point-to-point link between two neighbouring nodes. Its transmit half takes packets from the layer above as a 32-bit word stream and wraps each one in a light frame. Between packets it inserts control frames that carry the local node's status word. Every frame starts with a reserved marker word, and the word after the marker names the frame type. A payload word that happens to equal the marker is escaped, so the far end never confuses data with framing.

The receive half hunts for the marker and tells control frames from data frames. It checks a CRC-16 on each frame. Data payload is held in a small commit buffer and is released upward only after its CRC has matched. Frames that fail the check, overrun the buffer or break the framing are discarded and raise a one-cycle error pulse. Good control frames come out as a one-cycle status strobe. The two halves share nothing except clock and reset, so both directions run at the same time.

Top module: `link_framer`

## Requirements
- R1: A data frame is sent as marker 32'hFB5C_C5FB, type word 32'h0000_0001 (start), the payload words, marker, type word 32'h0000_0002 (end), then a check word {16'h0000, crc}. The crc is CRC-16 with polynomial 0x1021 and initial value 0xFFFF. It is computed over the unstuffed payload words, each word fed most significant bit first, with no reflection and no final inversion.
- R2: A payload word equal to the marker is sent as the marker followed by the escape word 32'h0000_0004. The receiver turns that pair back into one payload word of marker value.
- R3: A status request captures the status word in the cycle of the request. The frame sent for it is marker, type word 32'h0000_0003, the captured status word, then the check word, with the crc computed over the status word alone.
- R4: A pending status frame goes out before any data frame that waits at a packet boundary, including a packet offered in the same cycle as the request. A request made while a data frame is in progress is sent right after that frame's check word.
- R5: While the link side holds ready low, the offered transmit word stays valid and unchanged, and the word stream that reaches the link is the same as with no stalls.
- R6: The receiver delivers the payload of a data frame upward, with last set on the final word only. No word of a frame is presented before that frame's check word has been accepted and has matched.
- R7: A control frame with a matching check word produces a one-cycle status strobe with the received status word. It produces no error.
- R8: A frame whose check word does not match is dropped: no payload words and no status strobe, and a one-cycle error pulse.
- R9: Words that arrive outside a frame and are not the marker are ignored without error. An unknown type word after a marker raises an error. A start word in the middle of a data frame discards the partial frame, raises an error and starts a new frame.
- R10: A data frame with more payload words than the buffer depth (default 8) is dropped with an error. The link does not stall, and the next good frame is delivered.
- R11: After reset no word is offered on either output stream, no strobe or error is raised, the transmit upstream ready is low and the link receive ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pkt_data | input | 32 | Outgoing packet word from the upper layer |
| tx_pkt_last | input | 1 | Marks the final word of an outgoing packet |
| tx_pkt_valid | input | 1 | Outgoing packet word valid |
| tx_pkt_ready | output | 1 | Framer takes the outgoing packet word |
| tx_stat_req | input | 1 | Request to send a status frame |
| tx_stat_word | input | 32 | Local status word, captured on request |
| ln_tx_data | output | 32 | Word to the link |
| ln_tx_valid | output | 1 | Link transmit word valid |
| ln_tx_ready | input | 1 | Link accepts the transmit word |
| ln_rx_data | input | 32 | Word from the link |
| ln_rx_valid | input | 1 | Link receive word valid |
| ln_rx_ready | output | 1 | Framer takes the receive word |
| rx_pkt_data | output | 32 | Received payload word to the upper layer |
| rx_pkt_last | output | 1 | Final word of a received packet |
| rx_pkt_valid | output | 1 | Received payload word valid |
| rx_pkt_ready | input | 1 | Upper layer takes the received word |
| rx_stat_word | output | 32 | Status word from the last good control frame |
| rx_stat_valid | output | 1 | One-cycle strobe for a new status word |
| rx_err | output | 1 | One-cycle pulse when a received frame is dropped |

## Verification
Control insertion and packet framing compete for the transmit side. A status request and the first word of a packet can both arrive in the same idle cycle. The bench starts both in the same clock cycle, expects the whole status frame before the data frame on the link, and compares every word against streams it builds itself. It also raises a request a few cycles into a long packet and checks that the status frame follows that packet's check word. It runs the same cases with the link stalling one cycle in three, expects word streams identical to the unstalled case, and checks that no data frame is split.

// File: rtl/lf_pkg.sv
`timescale 1ns/100ps
package lf_pkg;
    localparam int          WORD_W   = 32;
    localparam logic [31:0] MARK     = 32'hFB5C_C5FB;
    localparam logic [31:0] TY_START = 32'h0000_0001;
    localparam logic [31:0] TY_END   = 32'h0000_0002;
    localparam logic [31:0] TY_STAT  = 32'h0000_0003;
    localparam logic [31:0] TY_ESC   = 32'h0000_0004;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    typedef enum logic [3:0] {
        TX_IDLE, TX_CMARK, TX_CTYPE, TX_CSTAT, TX_CCRC,
        TX_DMARK, TX_DSTART, TX_DATA, TX_DESC,
        TX_EMARK, TX_ETYPE, TX_ECRC
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_HUNT, RX_TYPE, RX_STAT, RX_SCRC, RX_DATA, RX_DTYPE, RX_DCRC
    } rx_state_e;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [31:0] w);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 31; i >= 0; i--) begin
            fb = r[15] ^ w[i];
            r  = {r[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
        end
        return r;
    endfunction

    function automatic logic [31:0] crc_word(input logic [15:0] c);
        return {16'h0000, c};
    endfunction
endpackage

// File: rtl/lf_tx.sv
`timescale 1ns/100ps
module lf_tx
    import lf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] up_data,
    input  logic        up_last,
    input  logic        up_valid,
    output logic        up_ready,
    input  logic        st_req,
    input  logic [31:0] st_word,
    output logic [31:0] phy_data,
    output logic        phy_valid,
    input  logic        phy_ready
);
    tx_state_e   state;
    logic        pend;
    logic [31:0] st_lat, st_cur;
    logic [15:0] crc;
    logic        fire, take, pend_any;
    logic [31:0] st_sel;

    assign fire     = phy_valid && phy_ready;
    assign take     = up_valid && up_ready;
    assign pend_any = pend || st_req;
    assign st_sel   = st_req ? st_word : st_lat;

    always_comb begin
        phy_valid = 1'b1;
        phy_data  = MARK;
        up_ready  = 1'b0;
        case (state)
            TX_IDLE:   phy_valid = 1'b0;
            TX_CTYPE:  phy_data = TY_STAT;
            TX_CSTAT:  phy_data = st_cur;
            TX_CCRC,
            TX_ECRC:   phy_data = crc_word(crc);
            TX_DSTART: phy_data = TY_START;
            TX_ETYPE:  phy_data = TY_END;
            TX_DATA: begin
                phy_data  = up_data;
                phy_valid = up_valid;
                up_ready  = phy_ready && (up_data != MARK);
            end
            TX_DESC: begin
                phy_data = TY_ESC;
                up_ready = phy_ready;
            end
            default:   phy_data = MARK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TX_IDLE;
            pend   <= 1'b0;
            st_lat <= '0;
            st_cur <= '0;
            crc    <= CRC_INIT;
        end else begin
            if (st_req && state != TX_IDLE) begin
                pend   <= 1'b1;
                st_lat <= st_word;
            end
            case (state)
                TX_IDLE:
                    if (pend_any) begin
                        state  <= TX_CMARK;
                        st_cur <= st_sel;
                        crc    <= crc_step(CRC_INIT, st_sel);
                        pend   <= 1'b0;
                    end else if (up_valid) begin
                        state <= TX_DMARK;
                        crc   <= CRC_INIT;
                    end
                TX_CMARK:  if (fire) state <= TX_CTYPE;
                TX_CTYPE:  if (fire) state <= TX_CSTAT;
                TX_CSTAT:  if (fire) state <= TX_CCRC;
                TX_DMARK:  if (fire) state <= TX_DSTART;
                TX_DSTART: if (fire) state <= TX_DATA;
                TX_DATA:
                    if (take) begin
                        crc <= crc_step(crc, up_data);
                        if (up_last) state <= TX_EMARK;
                    end else if (fire) begin
                        state <= TX_DESC;
                    end
                TX_DESC:
                    if (take) begin
                        crc   <= crc_step(crc, up_data);
                        state <= up_last ? TX_EMARK : TX_DATA;
                    end
                TX_EMARK:  if (fire) state <= TX_ETYPE;
                TX_ETYPE:  if (fire) state <= TX_ECRC;
                TX_CCRC,
                TX_ECRC:   if (fire) state <= TX_IDLE;
                default:   state <= TX_IDLE;
            endcase
        end
    end

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phy_valid && !phy_ready) |=> (phy_valid && $stable(phy_data)));

    // R2
    tx_escape_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_DATA && fire && phy_data == MARK) |=> (phy_valid && phy_data == TY_ESC));

    // R4
    tx_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (state == TX_IDLE && pend_any) |=> (state == TX_CMARK && !up_ready));
endmodule

// File: rtl/lf_rxbuf.sv
`timescale 1ns/100ps
module lf_rxbuf #(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [31:0]                wr_data,
    input  logic                       commit,
    input  logic                       rollback,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     pend_cnt,
    output logic [31:0]                rd_data,
    output logic                       rd_last,
    output logic                       rd_valid,
    input  logic                       rd_ready
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

    logic [31:0]      mem [DEPTH];
    logic [DEPTH-1:0] lastf;
    logic [AW:0]      wp, cp, rp;
    logic [AW-1:0]    wlast_idx;

    assign full      = (wp - rp) == DEPTH_P;
    assign pend_cnt  = wp - cp;
    assign rd_valid  = rp != cp;
    assign rd_data   = mem[rp[AW-1:0]];
    assign rd_last   = lastf[rp[AW-1:0]];
    assign wlast_idx = wp[AW-1:0] - AW'(1);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wp[AW-1:0]] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            cp    <= '0;
            rp    <= '0;
            lastf <= '0;
        end else begin
            if (wr_en) begin
                lastf[wp[AW-1:0]] <= 1'b0;
                wp <= wp + 1'b1;
            end
            if (commit) begin
                cp <= wp;
                if (wp != cp) lastf[wlast_idx] <= 1'b1;
            end
            if (rollback) wp <= cp;
            if (rd_valid && rd_ready) rp <= rp + 1'b1;
        end
    end

    // R10
    buf_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !full);

    // R6
    buf_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_last)));
endmodule

// File: rtl/lf_rx.sv
`timescale 1ns/100ps
module lf_rx
    import lf_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [31:0]            phy_data,
    input  logic                   phy_valid,
    output logic                   phy_ready,
    output logic                   wr_en,
    output logic [31:0]            wr_data,
    output logic                   commit,
    output logic                   rollback,
    input  logic                   full,
    input  logic [$clog2(DEPTH):0] pend_cnt,
    output logic [31:0]            st_word,
    output logic                   st_valid,
    output logic                   err
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

    rx_state_e   state, nstate;
    logic [15:0] crc, ncrc;
    logic        drop, ndrop;
    logic        acc, bad, good_st, do_pay;
    logic [31:0] pw;

    assign acc       = phy_valid && phy_ready;
    assign phy_ready = !full || drop || (pend_cnt == DEPTH_P);
    assign wr_data   = pw;

    always_comb begin
        nstate   = state;
        ncrc     = crc;
        ndrop    = drop;
        bad      = 1'b0;
        good_st  = 1'b0;
        commit   = 1'b0;
        rollback = 1'b0;
        wr_en    = 1'b0;
        do_pay   = 1'b0;
        pw       = phy_data;
        if (acc) begin
            case (state)
                RX_HUNT: if (phy_data == MARK) nstate = RX_TYPE;
                RX_TYPE:
                    if (phy_data == TY_START) begin
                        nstate = RX_DATA; ncrc = CRC_INIT; ndrop = 1'b0;
                    end else if (phy_data == TY_STAT) begin
                        nstate = RX_STAT;
                    end else begin
                        nstate = RX_HUNT; bad = 1'b1;
                    end
                RX_STAT: begin
                    ncrc   = crc_step(CRC_INIT, phy_data);
                    nstate = RX_SCRC;
                end
                RX_SCRC: begin
                    if (phy_data == crc_word(crc)) good_st = 1'b1;
                    else                           bad     = 1'b1;
                    nstate = RX_HUNT;
                end
                RX_DATA:
                    if (phy_data == MARK) nstate = RX_DTYPE;
                    else                  do_pay = 1'b1;
                RX_DTYPE:
                    if (phy_data == TY_ESC) begin
                        do_pay = 1'b1; pw = MARK; nstate = RX_DATA;
                    end else if (phy_data == TY_END) begin
                        nstate = RX_DCRC;
                    end else if (phy_data == TY_START) begin
                        rollback = 1'b1; bad = 1'b1;
                        ncrc = CRC_INIT; ndrop = 1'b0; nstate = RX_DATA;
                    end else begin
                        rollback = 1'b1; bad = 1'b1; nstate = RX_HUNT;
                    end
                RX_DCRC: begin
                    if (!drop && phy_data == crc_word(crc)) begin
                        commit = 1'b1;
                    end else begin
                        rollback = 1'b1;
                        bad      = !drop;
                    end
                    nstate = RX_HUNT;
                end
                default: nstate = RX_HUNT;
            endcase
            if (do_pay) begin
                ncrc = crc_step(crc, pw);
                if (!drop) begin
                    if (pend_cnt == DEPTH_P) begin
                        ndrop = 1'b1; rollback = 1'b1; bad = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_HUNT;
            crc      <= CRC_INIT;
            drop     <= 1'b0;
            st_word  <= '0;
            st_valid <= 1'b0;
            err      <= 1'b0;
        end else begin
            state    <= nstate;
            crc      <= ncrc;
            drop     <= ndrop;
            st_valid <= good_st;
            err      <= bad;
            if (acc && state == RX_STAT) st_word <= phy_data;
        end
    end

    // R9
    rx_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && state == RX_HUNT && phy_data != MARK) |=> (state == RX_HUNT && !err));

    // R8
    rx_drop_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && state == RX_DCRC && phy_data != crc_word(crc)) |-> !commit);
endmodule

// File: rtl/link_framer.sv
`timescale 1ns/100ps
module link_framer #(
    parameter int BUF_DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] tx_pkt_data,
    input  logic        tx_pkt_last,
    input  logic        tx_pkt_valid,
    output logic        tx_pkt_ready,
    input  logic        tx_stat_req,
    input  logic [31:0] tx_stat_word,
    output logic [31:0] ln_tx_data,
    output logic        ln_tx_valid,
    input  logic        ln_tx_ready,
    input  logic [31:0] ln_rx_data,
    input  logic        ln_rx_valid,
    output logic        ln_rx_ready,
    output logic [31:0] rx_pkt_data,
    output logic        rx_pkt_last,
    output logic        rx_pkt_valid,
    input  logic        rx_pkt_ready,
    output logic [31:0] rx_stat_word,
    output logic        rx_stat_valid,
    output logic        rx_err
);
    localparam int AW = $clog2(BUF_DEPTH);

    logic          b_wr_en, b_commit, b_rollback, b_full;
    logic [31:0]   b_wr_data;
    logic [AW:0]   b_pend;

    lf_tx u_tx (
        .clk(clk), .rst(rst),
        .up_data(tx_pkt_data), .up_last(tx_pkt_last),
        .up_valid(tx_pkt_valid), .up_ready(tx_pkt_ready),
        .st_req(tx_stat_req), .st_word(tx_stat_word),
        .phy_data(ln_tx_data), .phy_valid(ln_tx_valid), .phy_ready(ln_tx_ready)
    );

    lf_rx #(.DEPTH(BUF_DEPTH)) u_rx (
        .clk(clk), .rst(rst),
        .phy_data(ln_rx_data), .phy_valid(ln_rx_valid), .phy_ready(ln_rx_ready),
        .wr_en(b_wr_en), .wr_data(b_wr_data),
        .commit(b_commit), .rollback(b_rollback),
        .full(b_full), .pend_cnt(b_pend),
        .st_word(rx_stat_word), .st_valid(rx_stat_valid), .err(rx_err)
    );

    lf_rxbuf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk(clk), .rst(rst),
        .wr_en(b_wr_en), .wr_data(b_wr_data),
        .commit(b_commit), .rollback(b_rollback),
        .full(b_full), .pend_cnt(b_pend),
        .rd_data(rx_pkt_data), .rd_last(rx_pkt_last),
        .rd_valid(rx_pkt_valid), .rd_ready(rx_pkt_ready)
    );
endmodule

// File: tb/test_link_framer.sv
`timescale 1ns/100ps
module test_link_framer;
    typedef logic [31:0] wq_t [$];

    localparam logic [31:0] MK  = 32'hFB5C_C5FB;
    localparam logic [31:0] T_S = 32'h1;
    localparam logic [31:0] T_E = 32'h2;
    localparam logic [31:0] T_C = 32'h3;
    localparam logic [31:0] T_X = 32'h4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] tx_pkt_data = '0;
    logic        tx_pkt_last = 1'b0, tx_pkt_valid = 1'b0, tx_pkt_ready;
    logic        tx_stat_req = 1'b0;
    logic [31:0] tx_stat_word = '0;
    logic [31:0] ln_tx_data;
    logic        ln_tx_valid, ln_tx_ready = 1'b1;
    logic [31:0] ln_rx_data = '0;
    logic        ln_rx_valid = 1'b0, ln_rx_ready;
    logic [31:0] rx_pkt_data;
    logic        rx_pkt_last, rx_pkt_valid;
    logic        rx_pkt_ready = 1'b1;
    logic [31:0] rx_stat_word;
    logic        rx_stat_valid, rx_err;

    int    n_chk = 0, n_fail = 0, err_cnt = 0, cyc = 0;
    bit    stall_en = 1'b0;
    wq_t   tx_cap, exp_q, rx_cap, stat_cap;
    logic  last_cap [$];

    always #2.5 clk = ~clk;

    link_framer i_link_framer (.*);

    always @(posedge clk) begin
        #1;
        cyc++;
        ln_tx_ready = stall_en ? (cyc % 3 != 0) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (ln_tx_valid && ln_tx_ready) tx_cap.push_back(ln_tx_data);
            if (rx_pkt_valid && rx_pkt_ready) begin
                rx_cap.push_back(rx_pkt_data);
                last_cap.push_back(rx_pkt_last);
            end
            if (rx_stat_valid) stat_cap.push_back(rx_stat_word);
            if (rx_err) err_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] tb_crc(input wq_t ws);
        logic [15:0] c = 16'hFFFF;
        foreach (ws[k]) begin
            for (int b = 31; b >= 0; b--) begin
                if (c[15] ^ ws[k][b]) c = (c << 1) ^ 16'h1021;
                else                  c = c << 1;
            end
        end
        return c;
    endfunction

    function automatic wq_t enc_data(input wq_t ws);
        wq_t o;
        o.push_back(MK); o.push_back(T_S);
        foreach (ws[k]) begin
            if (ws[k] == MK) begin o.push_back(MK); o.push_back(T_X); end
            else o.push_back(ws[k]);
        end
        o.push_back(MK); o.push_back(T_E); o.push_back({16'h0, tb_crc(ws)});
        return o;
    endfunction

    function automatic wq_t enc_stat(input logic [31:0] s);
        wq_t o;
        wq_t one;
        one.push_back(s);
        o.push_back(MK); o.push_back(T_C); o.push_back(s); o.push_back({16'h0, tb_crc(one)});
        return o;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic send_pkt(input wq_t ws);
        bit ok;
        foreach (ws[k]) begin
            tx_pkt_data  = ws[k];
            tx_pkt_last  = (k == ws.size() - 1);
            tx_pkt_valid = 1'b1;
            forever begin
                @(negedge clk); ok = tx_pkt_ready;
                @(posedge clk); #1;
                if (ok) break;
            end
        end
        tx_pkt_valid = 1'b0;
        tx_pkt_last  = 1'b0;
    endtask

    task automatic stat_pulse(input logic [31:0] s);
        tx_stat_word = s;
        tx_stat_req  = 1'b1;
        tick(1);
        tx_stat_req  = 1'b0;
        tx_stat_word = 32'hDEAD_0000;
    endtask

    task automatic cmp_tx(input string tag);
        int t = 0;
        while (tx_cap.size() < exp_q.size() && t < 400) begin tick(1); t++; end
        tick(4);
        chk(tx_cap.size() == exp_q.size(), {tag, " length"}, tx_cap.size(), exp_q.size());
        foreach (exp_q[k]) begin
            if (k < tx_cap.size())
                chk(tx_cap[k] === exp_q[k], $sformatf("%s word %0d", tag, k), tx_cap[k], exp_q[k]);
        end
        tx_cap.delete(); exp_q.delete();
    endtask

    task automatic rx_word(input logic [31:0] w);
        bit ok;
        ln_rx_data  = w;
        ln_rx_valid = 1'b1;
        forever begin
            @(negedge clk); ok = ln_rx_ready;
            @(posedge clk); #1;
            if (ok) break;
        end
        ln_rx_valid = 1'b0;
    endtask

    task automatic rx_seq(input wq_t ws);
        foreach (ws[k]) rx_word(ws[k]);
    endtask

    task automatic rx_clear();
        rx_cap.delete(); last_cap.delete(); stat_cap.delete(); err_cnt = 0;
    endtask

    task automatic cmp_rx(input string tag, input wq_t exp, input int exp_err);
        tick(6);
        chk(rx_cap.size() == exp.size(), {tag, " count"}, rx_cap.size(), exp.size());
        foreach (exp[k]) begin
            if (k < rx_cap.size()) begin
                chk(rx_cap[k] === exp[k], $sformatf("%s data %0d", tag, k), rx_cap[k], exp[k]);
                chk(last_cap[k] === (k == exp.size() - 1), $sformatf("%s last %0d", tag, k),
                    {31'h0, last_cap[k]}, {31'h0, k == exp.size() - 1});
            end
        end
        chk(err_cnt == exp_err, {tag, " errors"}, err_cnt, exp_err);
        rx_clear();
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(ln_tx_valid == 1'b0, "R11 ln_tx_valid", {31'h0, ln_tx_valid}, 0);
        chk(rx_pkt_valid == 1'b0, "R11 rx_pkt_valid", {31'h0, rx_pkt_valid}, 0);
        chk(rx_stat_valid == 1'b0 && rx_err == 1'b0, "R11 strobes", {30'h0, rx_stat_valid, rx_err}, 0);
        chk(tx_pkt_ready == 1'b0, "R11 tx_pkt_ready", {31'h0, tx_pkt_ready}, 0);
        chk(ln_rx_ready == 1'b1, "R11 ln_rx_ready", {31'h0, ln_rx_ready}, 1);
    endtask

    task automatic t_tx_basic();
        wq_t p = '{32'h1111_0001, 32'h2222_0002, 32'h3333_0003};
        exp_q = enc_data(p);
        send_pkt(p);
        cmp_tx("R1 data frame");
    endtask

    task automatic t_tx_stuff();
        wq_t p = '{32'hA0A0_0000, MK, MK, 32'h0B0B_0000, MK};
        exp_q = enc_data(p);
        send_pkt(p);
        cmp_tx("R2 stuffed frame");
    endtask

    task automatic t_tx_stat();
        exp_q = enc_stat(32'h5A5A_1234);
        stat_pulse(32'h5A5A_1234);
        cmp_tx("R3 status frame");
    endtask

    task automatic t_same_cycle();
        wq_t p = '{32'h0000_00C1, 32'h0000_00C2};
        wq_t q = '{32'h10, 32'h11, 32'h12, 32'h13, 32'h14, 32'h15};
        exp_q = enc_stat(32'h0F0F_0F0F);
        foreach (p[k]) ;
        begin
            wq_t d = enc_data(p);
            foreach (d[k]) exp_q.push_back(d[k]);
        end
        fork
            stat_pulse(32'h0F0F_0F0F);
            send_pkt(p);
        join
        cmp_tx("R4 same cycle");
        exp_q = enc_data(q);
        begin
            wq_t s = enc_stat(32'h7777_0001);
            foreach (s[k]) exp_q.push_back(s[k]);
        end
        fork
            send_pkt(q);
            begin tick(4); stat_pulse(32'h7777_0001); end
        join
        cmp_tx("R4 mid frame");
    endtask

    task automatic t_tx_stall();
        wq_t p = '{32'h1, MK, 32'h3, 32'h4};
        stall_en = 1'b1;
        exp_q = enc_stat(32'hCAFE_0001);
        begin
            wq_t d = enc_data(p);
            foreach (d[k]) exp_q.push_back(d[k]);
        end
        fork
            stat_pulse(32'hCAFE_0001);
            send_pkt(p);
        join
        cmp_tx("R5 stalled link");
        stall_en = 1'b0;
    endtask

    task automatic t_rx_data();
        wq_t p = '{32'h0000_AAAA, 32'h0000_BBBB, 32'h0000_CCCC};
        wq_t f = enc_data(p);
        wq_t none;
        rx_clear();
        for (int k = 0; k < f.size() - 1; k++) rx_word(f[k]);
        tick(5);
        chk(rx_cap.size() == 0, "R6 held before check word", rx_cap.size(), 0);
        rx_word(f[f.size() - 1]);
        cmp_rx("R6 good frame", p, 0);
        none = '{};
        none.push_back(32'h0000_0099);
        rx_seq(enc_data(none));
        cmp_rx("R6 single word", none, 0);
    endtask

    task automatic t_rx_stuff();
        wq_t p = '{MK, 32'h5, MK};
        rx_clear();
        rx_seq(enc_data(p));
        cmp_rx("R2 unstuff", p, 0);
    endtask

    task automatic t_rx_stat();
        rx_clear();
        rx_seq(enc_stat(MK));
        rx_seq(enc_stat(32'h1234_ABCD));
        tick(4);
        chk(stat_cap.size() == 2, "R7 status count", stat_cap.size(), 2);
        if (stat_cap.size() == 2) begin
            chk(stat_cap[0] === MK, "R7 status value 0", stat_cap[0], MK);
            chk(stat_cap[1] === 32'h1234_ABCD, "R7 status value 1", stat_cap[1], 32'h1234_ABCD);
        end
        chk(err_cnt == 0, "R7 no error", err_cnt, 0);
        rx_clear();
    endtask

    task automatic t_rx_bad();
        wq_t p = '{32'h1, 32'h2};
        wq_t f = enc_data(p);
        wq_t s = enc_stat(32'h4444_5555);
        wq_t none;
        rx_clear();
        f[f.size() - 1] ^= 32'h1;
        rx_seq(f);
        cmp_rx("R8 bad data crc", none, 1);
        s[3] ^= 32'h8000;
        rx_seq(s);
        tick(4);
        chk(stat_cap.size() == 0, "R8 bad status dropped", stat_cap.size(), 0);
        chk(err_cnt == 1, "R8 bad status error", err_cnt, 1);
        rx_clear();
    endtask

    task automatic t_rx_junk();
        wq_t p = '{32'h0000_0E01};
        wq_t q = '{32'h0000_0003};
        wq_t none;
        wq_t f;
        rx_clear();
        rx_seq('{32'h1234_5678, T_S, T_E});
        rx_seq(enc_data(p));
        cmp_rx("R9 junk ignored", p, 0);
        rx_seq('{MK, 32'h0000_0077});
        cmp_rx("R9 unknown type", none, 1);
        f = '{MK, T_S, 32'h1, 32'h2};
        foreach (q[k]) ;
        begin
            wq_t d = enc_data(q);
            foreach (d[k]) f.push_back(d[k]);
        end
        rx_seq(f);
        cmp_rx("R9 restart mid frame", q, 1);
    endtask

    task automatic t_rx_over();
        wq_t big;
        wq_t p = '{32'h0000_0FAB, 32'h0000_0FAC};
        wq_t none;
        rx_clear();
        for (int k = 0; k < 9; k++) big.push_back(32'h100 + k);
        rx_seq(enc_data(big));
        cmp_rx("R10 overlong dropped", none, 1);
        rx_seq(enc_data(p));
        cmp_rx("R10 next frame", p, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        t_reset();
        t_tx_basic();
        t_tx_stuff();
        t_tx_stat();
        t_same_cycle();
        t_tx_stall();
        t_rx_data();
        t_rx_stuff();
        t_rx_stat();
        t_rx_bad();
        t_rx_junk();
        t_rx_over();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule